// File: doc/BRIEF.md
# Digital Potentiometer Command Controller

This block sits behind the bit-level front end of a 2-wire serial slave that controls a 1024-position digital potentiometer. The front end handles bus conditions, address match and bit timing. It hands this block four things: a start pulse carrying the read/write direction bit, a stop pulse, a stream of received bytes, and a stream on which it takes bytes to send back to the master. The block keeps a volatile 10-bit wiper position register and four 10-bit storage registers. The storage registers stand in for nonvolatile cells and are loaded with parameter values at reset. The wiper position is driven out both as a binary value and as a one-hot tap select.

The byte after the address is the command. Its top three bits are an opcode, bit 4 must be zero, bits 3:2 pick a storage register, and bits 1:0 must be zero. The opcode is interpreted together with the direction bit, so the same opcode means different operations for reads and writes. Transfers of a value use two bytes. The first byte carries the top two bits in its bits 1:0, and its upper six bits are ignored when written and returned as zero when read. The second byte carries bits 7:0.

Every register change takes effect at the stop that closes a complete transaction. A change to a storage register then holds the block busy for `NV_CYCLES` clock cycles. While busy, the block ignores starts, so the front end can withhold the address acknowledge. On the receive stream a byte moves when `in_valid` and `in_ready` are both high, and `in_ready` never depends on `in_valid`. On the send stream `out_valid` and `out_data` stay constant until `out_ready` takes the byte.

Top module: `dpot_ctrl`

## Requirements
- R1: On the first cycle after reset, storage register 0 is copied into the wiper. From the second cycle after reset, `wiper_o` equals the reset value of storage register 0, `busy_o` is 0 and `out_valid` is 0.
- R2: Command 0xA0 with direction 0, followed by two data bytes, sets the wiper at the stop. Only bits 1:0 of the first data byte are used (value bits 9:8). The second data byte gives bits 7:0.
- R3: Command 0x80 with direction 1 returns the wiper as two bytes: first {000000, bits 9:8}, then bits 7:0. A byte stays presented, unchanged, until `out_ready` takes it.
- R4: Command 0xC0|(s<<2) with direction 0, followed by two data bytes, writes storage register s at the stop when `protect_n` is high. `busy_o` then goes high in the cycle after the stop and stays high for exactly `NV_CYCLES` cycles. A start that arrives while busy is ignored, and `in_ready` stays low.
- R5: Command 0xA0|(s<<2) with direction 1 returns storage register s in the same two-byte format as R3.
- R6: Command 0xC0|(s<<2) with direction 1, with no data bytes, copies storage register s into the wiper at the stop. It does not set busy.
- R7: Command 0xE0|(s<<2) with direction 0, with no data bytes, copies the wiper into storage register s at the stop. It then sets busy exactly as R4.
- R8: While `protect_n` is low, the storage writes of R4 and R7 leave every storage register unchanged and do not set busy.
- R9: A stop or a new start before every byte of a command has arrived changes no register and does not set busy.
- R10: A command byte with bit 4 or bits 1:0 nonzero, or with an opcode/direction pair not listed in R2 to R7, is ignored. `in_ready` and `out_valid` stay low until the stop, and no register changes.
- R11: `tap_o` has exactly one bit set, at index `wiper_o` (0x000 is the low end, 0x3FF the high end).
- R12: `in_ready` is high only while the block waits for a command byte or a write data byte. It is low when no transaction is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| protect_n | input | 1 | Low blocks writes to the storage registers |
| bus_start | input | 1 | Pulse: address matched, transaction opens |
| bus_rw | input | 1 | Direction bit, sampled with `bus_start` (1 = read) |
| bus_stop | input | 1 | Pulse: transaction closes |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Block accepts the received byte |
| out_valid | output | 1 | Byte to send is valid |
| out_data | output | 8 | Byte to send |
| out_ready | input | 1 | Front end takes the byte |
| busy_o | output | 1 | Storage write in progress |
| wiper_o | output | W | Wiper position |
| tap_o | output | 2**W | One-hot tap select |

## Verification
Commits happen on the clock edge that samples `bus_stop`. The bench drives `bus_stop` for one cycle from a falling edge and checks `wiper_o`, `tap_o` and `busy_o` at the next falling edge, the first point after that commit edge. The first busy sample therefore falls in the cycle right after the stop, and the bench counts high samples until busy drops, expecting `NV_CYCLES`. Read bytes appear on the send stream one edge after the command byte is taken. A scoreboard compares each byte at the falling edge where `out_valid` and `out_ready` are both high, while `out_ready` is throttled to force stalls. Ignored commands are checked by holding a byte on the receive stream for several cycles and confirming it is never taken, then reading the registers back.

// File: rtl/potc_pkg.sv
package potc_pkg;
  localparam int SEL_W = 2;
  localparam int NREG  = 2 ** SEL_W;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD_W = 3'd1,
    CMD_WR_W = 3'd2,
    CMD_RD_D = 3'd3,
    CMD_WR_D = 3'd4,
    CMD_LD_W = 3'd5,
    CMD_ST_D = 3'd6
  } cmd_e;

  // opcode is meaningful only together with the direction bit
  function automatic cmd_e decode_cmd(input logic [7:0] b, input logic rd);
    cmd_e c;
    if (b[4] || (b[1:0] != 2'b00)) return CMD_NONE;
    case ({rd, b[7:5]})
      4'b1100: c = CMD_RD_W;
      4'b0101: c = CMD_WR_W;
      4'b1101: c = CMD_RD_D;
      4'b0110: c = CMD_WR_D;
      4'b1110: c = CMD_LD_W;
      4'b0111: c = CMD_ST_D;
      default: c = CMD_NONE;
    endcase
    return c;
  endfunction

  function automatic logic is_store(input cmd_e c);
    return (c == CMD_WR_D) || (c == CMD_ST_D);
  endfunction
endpackage

// File: rtl/potc_seq.sv
module potc_seq
  import potc_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy_i,
  input  logic                    start_i,
  input  logic                    rw_i,
  input  logic                    stop_i,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic [7:0]              out_data,
  input  logic                    out_ready,
  input  logic [W-1:0]            rd_wcr_i,
  input  logic [NREG-1:0][W-1:0]  rd_dr_i,
  output logic                    commit_o,
  output cmd_e                    commit_op_o,
  output logic [SEL_W-1:0]        commit_sel_o,
  output logic [W-1:0]            commit_data_o
);
  localparam int HI_W = W - 8;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WHI, S_WLO, S_RHI, S_RLO, S_ARMED, S_DROP
  } st_e;

  st_e              st_q;
  logic             rd_q;
  cmd_e             op_q;
  logic [SEL_W-1:0] sel_q;
  logic [W-1:0]     val_q;
  logic             take;
  cmd_e             cmd_now;
  logic [SEL_W-1:0] sel_now;

  assign in_ready  = (st_q == S_CMD) || (st_q == S_WHI) || (st_q == S_WLO);
  assign take      = in_valid && in_ready;
  assign cmd_now   = decode_cmd(in_data, rd_q);
  assign sel_now   = in_data[3:2];
  assign out_valid = (st_q == S_RHI) || (st_q == S_RLO);
  assign out_data  = (st_q == S_RHI) ? {{(16-W){1'b0}}, val_q[W-1:8]} : val_q[7:0];

  assign commit_o      = (st_q == S_ARMED) && stop_i;
  assign commit_op_o   = op_q;
  assign commit_sel_o  = sel_q;
  assign commit_data_o = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      rd_q  <= 1'b0;
      op_q  <= CMD_NONE;
      sel_q <= '0;
      val_q <= '0;
    end else if (stop_i) begin
      st_q <= S_IDLE;
    end else if (start_i) begin
      st_q <= busy_i ? S_IDLE : S_CMD;
      rd_q <= rw_i;
    end else begin
      case (st_q)
        S_CMD: if (take) begin
          op_q  <= cmd_now;
          sel_q <= sel_now;
          case (cmd_now)
            CMD_NONE: st_q <= S_DROP;
            CMD_RD_W: begin val_q <= rd_wcr_i;         st_q <= S_RHI; end
            CMD_RD_D: begin val_q <= rd_dr_i[sel_now]; st_q <= S_RHI; end
            CMD_WR_W, CMD_WR_D: st_q <= S_WHI;
            default:  st_q <= S_ARMED;
          endcase
        end
        S_WHI: if (take) begin
          val_q[W-1:8] <= in_data[HI_W-1:0];
          st_q <= S_WLO;
        end
        S_WLO: if (take) begin
          val_q[7:0] <= in_data;
          st_q <= S_ARMED;
        end
        S_RHI: if (out_ready) st_q <= S_RLO;
        S_RLO: if (out_ready) st_q <= S_DROP;
        default: ;
      endcase
    end
  end

  // send stream holds its byte under back-pressure
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !stop_i && !start_i) |=> (out_valid && $stable(out_data)));
  // a start while busy opens nothing
  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && start_i && !stop_i) |=> !in_ready);
  // stop always closes the transaction
  p_stop_closes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!in_ready && !out_valid));
endmodule

// File: rtl/potc_regs.sv
module potc_regs
  import potc_pkg::*;
#(
  parameter int W = 10,
  parameter logic [NREG*W-1:0] DR_INIT = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    protect_n,
  input  logic                    commit_i,
  input  cmd_e                    op_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [W-1:0]            data_i,
  output logic [W-1:0]            wcr_o,
  output logic [NREG-1:0][W-1:0]  dr_o,
  output logic                    nv_go_o
);
  logic [W-1:0]           wcr_q;
  logic [NREG-1:0][W-1:0] dr_q;
  logic                   recall_q;

  assign nv_go_o = commit_i && protect_n && is_store(op_i);
  assign wcr_o   = wcr_q;
  assign dr_o    = dr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcr_q    <= '0;
      dr_q     <= DR_INIT;
      recall_q <= 1'b1;
    end else begin
      recall_q <= 1'b0;
      if (recall_q) wcr_q <= dr_q[0];
      else if (commit_i && (op_i == CMD_WR_W)) wcr_q <= data_i;
      else if (commit_i && (op_i == CMD_LD_W)) wcr_q <= dr_q[sel_i];
      if (nv_go_o) dr_q[sel_i] <= (op_i == CMD_WR_D) ? data_i : wcr_q;
    end
  end

  // power-up recall of register 0
  p_recall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    recall_q |=> (wcr_q == $past(dr_q[0])));
  // wiper only moves on a committed command
  p_wcr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i && !recall_q) |=> $stable(wcr_q));
  // protect blocks storage writes
  p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !protect_n |=> $stable(dr_q));
endmodule

// File: rtl/potc_nvtimer.sv
module potc_nvtimer #(
  parameter int NV_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o
);
  localparam int CW = $clog2(NV_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(NV_CYCLES);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (go_i)        cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> busy_o);
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && !go_i) |=> !busy_o);
endmodule

// File: rtl/potc_tapdec.sv
module potc_tapdec #(
  parameter int W = 10
) (
  input  logic [W-1:0]      pos_i,
  output logic [2**W-1:0]   tap_o
);
  localparam int TAPS = 2 ** W;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_o[i] = (pos_i == W'(i));
  end
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import potc_pkg::*;
#(
  parameter int W = 10,
  parameter int NV_CYCLES = 1000000,
  parameter logic [NREG*W-1:0] DR_INIT = {10'h000, 10'h3FF, 10'h2AA, 10'h155}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            protect_n,
  input  logic            bus_start,
  input  logic            bus_rw,
  input  logic            bus_stop,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  output logic            out_valid,
  output logic [7:0]      out_data,
  input  logic            out_ready,
  output logic            busy_o,
  output logic [W-1:0]    wiper_o,
  output logic [2**W-1:0] tap_o
);
  logic                   commit;
  cmd_e                   commit_op;
  logic [SEL_W-1:0]       commit_sel;
  logic [W-1:0]           commit_data;
  logic [W-1:0]           wcr;
  logic [NREG-1:0][W-1:0] dr;
  logic                   nv_go;

  potc_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_o),
    .start_i(bus_start), .rw_i(bus_rw), .stop_i(bus_stop),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .rd_wcr_i(wcr), .rd_dr_i(dr),
    .commit_o(commit), .commit_op_o(commit_op),
    .commit_sel_o(commit_sel), .commit_data_o(commit_data)
  );

  potc_regs #(.W(W), .DR_INIT(DR_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .protect_n(protect_n),
    .commit_i(commit), .op_i(commit_op), .sel_i(commit_sel),
    .data_i(commit_data), .wcr_o(wcr), .dr_o(dr), .nv_go_o(nv_go)
  );

  potc_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go_i(nv_go), .busy_o(busy_o)
  );

  potc_tapdec #(.W(W)) u_tap (.pos_i(wcr), .tap_o(tap_o));

  assign wiper_o = wcr;

  p_tap_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_o) == 1) && tap_o[wiper_o]);
  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !in_ready && !bus_start) |=> !in_ready);
endmodule

// File: tb/sim_dpot_ctrl.sv
`timescale 1ns/1ps
module sim_dpot_ctrl;
  localparam int W  = 10;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic protect_n = 1'b1;
  logic bus_start = 1'b0, bus_rw = 1'b0, bus_stop = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_ready = 1'b0, busy_o;
  logic [7:0] out_data;
  logic [W-1:0] wiper_o;
  logic [2**W-1:0] tap_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int unsigned cyc = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [W-1:0] m_wcr;
  logic [W-1:0] m_dr [4];

  always #2.5 clk = ~clk;

  dpot_ctrl #(.W(W), .NV_CYCLES(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .protect_n(protect_n),
    .bus_start(bus_start), .bus_rw(bus_rw), .bus_stop(bus_stop),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy_o(busy_o), .wiper_o(wiper_o), .tap_o(tap_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // throttled send-side ready, driven away from the sampling edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready <= (cyc % 3) != 0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected send byte", out_data, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end
  end

  task automatic start_txn(input logic rd);
    bus_start = 1'b1; bus_rw = rd;
    @(negedge clk);
    bus_start = 1'b0;
  endtask

  task automatic stop_txn();
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ok);
    ok = 1'b0;
    in_valid = 1'b1; in_data = b;
    for (int k = 0; k < 8; k++) begin
      if (in_ready) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (ok) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic rd, input logic [7:0] c, input logic [7:0] b1,
                          input logic [7:0] b2, input int nbytes, input bit do_stop);
    bit ok;
    start_txn(rd);
    put_byte(c, ok);
    if (nbytes > 0) put_byte(b1, ok);
    if (nbytes > 1) put_byte(b2, ok);
    if (do_stop) stop_txn();
  endtask

  task automatic read_cmd(input logic [7:0] c, input logic [W-1:0] expv, input string tag);
    bit ok;
    exp_q.push_back({6'b0, expv[9:8]}); tag_q.push_back({tag, " high byte"});
    exp_q.push_back(expv[7:0]);         tag_q.push_back({tag, " low byte"});
    start_txn(1'b1);
    put_byte(c, ok);
    for (int k = 0; k < 60 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, {tag, " read completes"}, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
    stop_txn();
  endtask

  task automatic wait_idle();
    for (int k = 0; k < NV + 10 && busy_o; k++) @(negedge clk);
  endtask

  task automatic count_busy(input string tag);
    int n = 0;
    while (busy_o && n < NV + 10) begin n++; @(negedge clk); end
    check(n == NV, tag, n, NV);
  endtask

  initial begin
    bit ok;
    m_dr[0] = 10'h155; m_dr[1] = 10'h2AA; m_dr[2] = 10'h3FF; m_dr[3] = 10'h000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    m_wcr = m_dr[0];
    // R1 reset state and power-up recall
    check(wiper_o == m_wcr, "R1 recall wiper", wiper_o, m_wcr);
    check(busy_o == 1'b0, "R1 busy low", busy_o, 0);
    check(out_valid == 1'b0, "R1 out_valid low", out_valid, 0);
    check(tap_o[m_wcr] && $countones(tap_o) == 1, "R11 tap after reset", $countones(tap_o), 1);
    check(in_ready == 1'b0, "R12 idle not ready", in_ready, 0);

    // R3 read wiper with stalls
    read_cmd(8'h80, m_wcr, "R3 read wiper");

    // R2 write wiper, junk in upper bits of first byte
    send_cmd(1'b0, 8'hA0, 8'hFE, 8'hC7, 2, 1'b1);
    m_wcr = 10'h2C7;
    check(wiper_o == m_wcr, "R2 write wiper", wiper_o, m_wcr);
    check(tap_o[m_wcr] && $countones(tap_o) == 1, "R11 tap follows wiper", $countones(tap_o), 1);
    check(busy_o == 1'b0, "R2 no busy", busy_o, 0);

    // R5 read storage registers
    read_cmd(8'hA4, m_dr[1], "R5 read reg1");
    read_cmd(8'hA8, m_dr[2], "R5 read reg2");

    // R4 storage write, busy and ignored start
    send_cmd(1'b0, 8'hC8, 8'h01, 8'hA5, 2, 1'b1);
    m_dr[2] = 10'h1A5;
    check(busy_o == 1'b1, "R4 busy after store", busy_o, 1);
    start_txn(1'b0);
    check(in_ready == 1'b0, "R4 start ignored while busy", in_ready, 0);
    put_byte(8'hA0, ok);
    check(ok == 1'b0, "R4 byte refused while busy", ok, 0);
    stop_txn();
    wait_idle();
    read_cmd(8'hA8, m_dr[2], "R4 stored reg2");

    // R12 ready only while awaiting bytes
    start_txn(1'b0);
    check(in_ready == 1'b1, "R12 ready after start", in_ready, 1);
    stop_txn();
    check(in_ready == 1'b0, "R12 not ready after stop", in_ready, 0);

    // R6 copy reg1 to wiper
    send_cmd(1'b1, 8'hC4, 8'h00, 8'h00, 0, 1'b1);
    m_wcr = m_dr[1];
    check(wiper_o == m_wcr, "R6 copy to wiper", wiper_o, m_wcr);
    check(busy_o == 1'b0, "R6 no busy", busy_o, 0);

    // R7 copy wiper to reg3, exact busy length
    send_cmd(1'b0, 8'hA0, 8'h00, 8'hF0, 2, 1'b1);
    m_wcr = 10'h0F0;
    send_cmd(1'b0, 8'hEC, 8'h00, 8'h00, 0, 1'b1);
    m_dr[3] = m_wcr;
    count_busy("R7 busy length");
    read_cmd(8'hAC, m_dr[3], "R7 stored reg3");

    // R8 protect low blocks stores
    protect_n = 1'b0;
    send_cmd(1'b0, 8'hC0, 8'h03, 8'hC3, 2, 1'b1);
    check(busy_o == 1'b0, "R8 no busy on blocked write", busy_o, 0);
    send_cmd(1'b0, 8'hE0, 8'h00, 8'h00, 0, 1'b1);
    check(busy_o == 1'b0, "R8 no busy on blocked copy", busy_o, 0);
    read_cmd(8'hA0, m_dr[0], "R8 reg0 unchanged");
    protect_n = 1'b1;

    // R9 early stop and restart
    send_cmd(1'b0, 8'hA0, 8'h01, 8'h11, 1, 1'b1);
    check(wiper_o == m_wcr, "R9 early stop keeps wiper", wiper_o, m_wcr);
    send_cmd(1'b0, 8'hC4, 8'h00, 8'h33, 2, 1'b0);
    start_txn(1'b0);
    stop_txn();
    check(busy_o == 1'b0, "R9 restart no busy", busy_o, 0);
    read_cmd(8'hA4, m_dr[1], "R9 reg1 unchanged");

    // R10 reserved bits and undefined pairs
    start_txn(1'b1);
    put_byte(8'h81, ok);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 reserved bit no reply", out_valid, 0);
    check(in_ready == 1'b0, "R10 reserved bit not ready", in_ready, 0);
    stop_txn();
    start_txn(1'b0);
    put_byte(8'h80, ok);
    put_byte(8'h00, ok);
    check(ok == 1'b0, "R10 undefined write refused", ok, 0);
    stop_txn();
    check(wiper_o == m_wcr, "R10 wiper unchanged", wiper_o, m_wcr);
    start_txn(1'b1);
    put_byte(8'hE0, ok);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 undefined read no reply", out_valid, 0);
    stop_txn();
    check(wiper_o == m_wcr && busy_o == 1'b0, "R10 no change", wiper_o, m_wcr);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule